// File: doc/BRIEF.md
# Multi-Request Watchdog Timer

This block is a watchdog counter driven by a slow-tick enable, meant to be a 32.768 kHz tick inside the fast clock domain. Software sets a reload value, picks which reload-request channels take part, and sets a few configuration bits. It then issues a start command. From then on the counter falls by one on every counting tick. When it runs out, the block raises a timeout, and that timeout always ends in a one-tick system-reset pulse. The processor's state has no say in this: a core stuck in a fault handler is still reset.

Software keeps the watchdog alive by writing a fixed key to the request register of every enabled channel. Only when all of them have been served since the last reload does the counter restart from the reload value. Two configuration bits decide whether ticks count while the processor is halted for debug and while it sleeps. If the timeout interrupt is enabled, the interrupt fires at the timeout and the reset follows exactly two ticks later. After the start command the configuration is frozen. The reset pulse returns the whole block to its stopped, unconfigured state.

Top module: `wdt_multireq`

## Requirements
- R1: After rst_n is released, irq and sys_reset are 0 and every readable register (CFG 0x1, LOAD 0x2, CHEN 0x3, STATUS 0x4, COUNT 0x5) reads 0.
- R2: Before a start command (write with bit 0 set to CTRL at 0x0) the counter does not run, no timeout occurs, and key writes have no effect.
- R3: Once started with LOAD = L, the timeout happens on the L-th counting tick after the start command or the last reload.
- R4: With CFG bit 2 (irq_en) clear, sys_reset rises on the same tick as the timeout and irq stays 0.
- R5: With CFG bit 2 set, irq rises on the timeout tick and sys_reset rises exactly two ticks later.
- R6: sys_reset stays high for exactly one tick period. The tick that ends it clears irq and returns all registers to their R1 values.
- R7: Writing key 0x6E524635 to channel register 0x8+i marks channel i as served, but only if CHEN bit i is set. Once every enabled channel has been served, the counter reloads from LOAD and all marks clear. Other values, and writes to disabled channels, are ignored.
- R8: STATUS bits [NUM_CH-1:0] show the enabled channels that still await a key. Bit 31 shows that the counter is running.
- R9: CFG bit 0 (run in halt) and CFG bit 1 (run in sleep) choose whether ticks count while cpu_halt or cpu_sleep is high. When the bit is clear, those ticks are not counted.
- R10: After start, writes to CFG, LOAD and CHEN are ignored until the reset pulse clears the block.
- R11: Once the timeout has happened, no key write or register write prevents or delays the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle slow-tick enable (32.768 kHz rate) |
| cpu_halt | input | 1 | Processor halted for debug |
| cpu_sleep | input | 1 | Processor asleep |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for write and read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Timeout interrupt, held until the reset pulse ends |
| sys_reset | output | 1 | System reset pulse, one tick long |

## Verification
Register writes take effect at the clock edge that samples them. Reads are combinational, so the bench samples them one time step after it changes the address on the falling edge. Every timed result is counted in ticks from the tick index just after the start command or the reload write:
- timeout at +L;
- sys_reset rise at +L without the interrupt, or at +L+2 with it;
- sys_reset fall one tick after its rise.

The driver pushes each expected edge, with its tick index, into a queue. A falling-edge monitor pops an entry for every edge of irq and sys_reset and compares the kind and the tick. Any edge that is missing, extra or late is therefore reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register word addresses
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_CFG    = 1;
  localparam int unsigned A_LOAD   = 2;
  localparam int unsigned A_CHEN   = 3;
  localparam int unsigned A_STATUS = 4;
  localparam int unsigned A_COUNT  = 5;
  localparam int unsigned A_CHBASE = 8;

  // Value that counts as a valid reload request
  localparam logic [31:0] RELOAD_KEY = 32'h6E52_4635;

  // Configuration bits, bit 0 is run_halt
  typedef struct packed {
    logic irq_en;
    logic run_sleep;
    logic run_halt;
  } wdt_cfg_t;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              running_i,
  input  logic              expired_i,
  input  logic [NUM_CH-1:0] pending_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output wdt_cfg_t          cfg_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [NUM_CH-1:0] chen_o,
  output logic              start_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned CFG_W = $bits(wdt_cfg_t);

  wdt_cfg_t          cfg_q, cfg_d;
  logic [CNT_W-1:0]  load_q, load_d;
  logic [NUM_CH-1:0] chen_q, chen_d;
  logic              locked;
  logic              hit_cfg, hit_load, hit_chen, hit_ctrl;

  assign locked   = running_i | expired_i;
  assign hit_ctrl = we_i && (addr_i == ADDR_W'(A_CTRL));
  assign hit_cfg  = we_i && (addr_i == ADDR_W'(A_CFG))  && !locked;
  assign hit_load = we_i && (addr_i == ADDR_W'(A_LOAD)) && !locked;
  assign hit_chen = we_i && (addr_i == ADDR_W'(A_CHEN)) && !locked;
  assign start_o  = hit_ctrl && wdata_i[0] && !locked;

  always_comb begin
    cfg_d  = cfg_q;
    load_d = load_q;
    chen_d = chen_q;
    if (clr_i) begin
      cfg_d  = '0;
      load_d = '0;
      chen_d = '0;
    end else begin
      if (hit_cfg)  cfg_d  = wdt_cfg_t'(wdata_i[CFG_W-1:0]);
      if (hit_load) load_d = wdata_i[CNT_W-1:0];
      if (hit_chen) chen_d = wdata_i[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      load_q <= '0;
      chen_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      load_q <= load_d;
      chen_q <= chen_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CFG):    rdata_o[CFG_W-1:0]  = cfg_q;
      ADDR_W'(A_LOAD):   rdata_o[CNT_W-1:0]  = load_q;
      ADDR_W'(A_CHEN):   rdata_o[NUM_CH-1:0] = chen_q;
      ADDR_W'(A_STATUS): begin
        rdata_o[NUM_CH-1:0] = pending_i;
        rdata_o[DATA_W-1]   = running_i;
      end
      ADDR_W'(A_COUNT):  rdata_o[CNT_W-1:0]  = cnt_i;
      default:           rdata_o = '0;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign load_o = load_q;
  assign chen_o = chen_q;

endmodule

// File: rtl/wdt_reload.sv
module wdt_reload
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              armed_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] chen_i,
  output logic              fire_o,
  output logic [NUM_CH-1:0] pending_o
);

  logic [NUM_CH-1:0] served_q, served_d;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] merged;
  logic              key_ok;

  assign key_ok = (wdata_i == DATA_W'(RELOAD_KEY));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit[i] = we_i && armed_i && key_ok && chen_i[i] &&
                    (addr_i == ADDR_W'(A_CHBASE + i));
  end

  assign merged = served_q | hit;
  assign fire_o = (|hit) && (chen_i != '0) && ((merged & chen_i) == chen_i);

  always_comb begin
    served_d = merged;
    if (clr_i || fire_o) served_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) served_q <= '0;
    else         served_q <= served_d;
  end

  assign pending_o = chen_i & ~served_q;

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned RST_DLY  = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             sleep_i,
  input  wdt_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             start_i,
  input  logic             reload_i,
  output logic             running_o,
  output logic             expired_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             sys_reset_o,
  output logic             clr_o
);

  localparam int unsigned DLY_W = $clog2(RST_DLY + 1);

  logic             run_q, run_d;
  logic             exp_q, exp_d;
  logic             rst_q, rst_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             cnt_en;
  logic             clr;

  assign clr    = rst_q && tick_i;
  assign cnt_en = tick_i && (cfg_i.run_halt || !halt_i) && (cfg_i.run_sleep || !sleep_i);

  always_comb begin
    run_d = run_q;
    exp_d = exp_q;
    rst_d = rst_q;
    irq_d = irq_q;
    cnt_d = cnt_q;
    dly_d = dly_q;
    if (clr) begin
      run_d = 1'b0;
      exp_d = 1'b0;
      rst_d = 1'b0;
      irq_d = 1'b0;
      cnt_d = '0;
      dly_d = '0;
    end else begin
      if (start_i && !run_q && !exp_q) begin
        run_d = 1'b1;
        cnt_d = load_i;
      end else if (run_q) begin
        if (reload_i) begin
          cnt_d = load_i;
        end else if (cnt_en) begin
          if (cnt_q <= CNT_W'(1)) begin
            cnt_d = '0;
            run_d = 1'b0;
            exp_d = 1'b1;
            if (cfg_i.irq_en) begin
              irq_d = 1'b1;
              dly_d = DLY_W'(RST_DLY);
            end else begin
              rst_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      // Deferred reset: counts every tick, whatever the processor does
      if (exp_q && !rst_q && tick_i && (dly_q != '0)) begin
        dly_d = dly_q - DLY_W'(1);
        if (dly_q == DLY_W'(1)) rst_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      exp_q <= 1'b0;
      rst_q <= 1'b0;
      irq_q <= 1'b0;
      cnt_q <= '0;
      dly_q <= '0;
    end else begin
      run_q <= run_d;
      exp_q <= exp_d;
      rst_q <= rst_d;
      irq_q <= irq_d;
      cnt_q <= cnt_d;
      dly_q <= dly_d;
    end
  end

  assign running_o   = run_q;
  assign expired_o   = exp_q;
  assign cnt_o       = cnt_q;
  assign irq_o       = irq_q;
  assign sys_reset_o = rst_q;
  assign clr_o       = clr;

endmodule

// File: rtl/wdt_multireq.sv
module wdt_multireq
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RST_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cpu_halt,
  input  logic              cpu_sleep,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_reset
);

  logic              rst_meta, rst_ni;
  wdt_cfg_t          cfg;
  logic [CNT_W-1:0]  load_val;
  logic [NUM_CH-1:0] chen;
  logic [NUM_CH-1:0] pending;
  logic [CNT_W-1:0]  cnt;
  logic              start, reload_fire, running, expired, clr;

  // Reset synchronizer: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  wdt_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .we_i      (bus_we),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .running_i (running),
    .expired_i (expired),
    .pending_i (pending),
    .cnt_i     (cnt),
    .cfg_o     (cfg),
    .load_o    (load_val),
    .chen_o    (chen),
    .start_o   (start),
    .rdata_o   (bus_rdata)
  );

  wdt_reload #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_reload (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .armed_i   (running),
    .we_i      (bus_we),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .chen_i    (chen),
    .fire_o    (reload_fire),
    .pending_o (pending)
  );

  wdt_core #(
    .CNT_W(CNT_W), .RST_DLY(RST_DLY)
  ) u_core (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick_en),
    .halt_i      (cpu_halt),
    .sleep_i     (cpu_sleep),
    .cfg_i       (cfg),
    .load_i      (load_val),
    .start_i     (start),
    .reload_i    (reload_fire),
    .running_o   (running),
    .expired_o   (expired),
    .cnt_o       (cnt),
    .irq_o       (irq),
    .sys_reset_o (sys_reset),
    .clr_o       (clr)
  );

endmodule

// File: rtl/wdt_multireq_chk.sv
module wdt_multireq_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             tick_en,
  input logic             bus_we,
  input logic             irq,
  input logic             sys_reset,
  input logic             running,
  input logic             expired,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val
);

  AST_RST_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    (sys_reset && tick_en) |=> !sys_reset); // R6

  AST_RST_ON_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sys_reset) |-> $past(tick_en)); // R3

  AST_RST_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_ni)
    sys_reset |-> expired); // R11

  AST_EXPIRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (expired && !(sys_reset && tick_en)) |=> expired); // R11

  AST_IRQ_LEADS_RST: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq) |-> !sys_reset); // R5

  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_en && !bus_we) |=> $stable(cnt)); // R9

  AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_ni)
    running |=> $stable(load_val)); // R10

endmodule

bind wdt_multireq wdt_multireq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .tick_en   (tick_en),
  .bus_we    (bus_we),
  .irq       (irq),
  .sys_reset (sys_reset),
  .running   (running),
  .expired   (expired),
  .cnt       (cnt),
  .load_val  (load_val)
);

// File: tb/wdt_multireq_tb.sv
module wdt_multireq_tb;

  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CNT_W  = 24;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] KEY    = 32'h6E52_4635;

  localparam int K_IRQ  = 0;
  localparam int K_RISE = 1;
  localparam int K_FALL = 2;

  logic              clk;
  logic              rst_n;
  logic              tick_en;
  logic              cpu_halt;
  logic              cpu_sleep;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;
  logic              sys_reset;

  int unsigned cyc;
  int          tick_num;
  int          n_checks;
  int          n_fail;
  int          exp_kind[$];
  int          exp_tick[$];
  logic        irq_prev;
  logic        rst_prev;

  wdt_multireq #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_DLY(2)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .cpu_halt  (cpu_halt),
    .cpu_sleep (cpu_sleep),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .sys_reset (sys_reset)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Slow tick: one cycle in eight
  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick_en = (cyc[2:0] == 3'd7);

  initial tick_num = 0;
  always @(posedge clk) if (tick_en) tick_num <= tick_num + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Scoreboard driver side
  task automatic expect_evt(input int kind, input int tk);
    exp_kind.push_back(kind);
    exp_tick.push_back(tk);
  endtask

  // Scoreboard monitor side
  task automatic pop_evt(input int kind);
    int k;
    int t;
    string req;
    req = (kind == K_IRQ) ? "R5" : (kind == K_RISE) ? "R3" : "R6";
    n_checks++;
    if (exp_kind.size() == 0) begin
      n_fail++;
      $display("FAIL %s: unexpected edge kind %0d at tick %0d, expected none", req, kind, tick_num);
    end else begin
      k = exp_kind.pop_front();
      t = exp_tick.pop_front();
      if (k != kind || t != tick_num) begin
        n_fail++;
        $display("FAIL %s: edge kind %0d at tick %0d, expected kind %0d at tick %0d",
                 req, kind, tick_num, k, t);
      end
    end
  endtask

  initial begin
    irq_prev = 1'b0;
    rst_prev = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !irq_prev)             pop_evt(K_IRQ);
      if (sys_reset && !rst_prev)       pop_evt(K_RISE);
      if (!sys_reset && rst_prev)       pop_evt(K_FALL);
    end
    irq_prev = irq;
    rst_prev = sys_reset;
  end

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = ADDR_W'(addr);
    bus_wdata = data;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd_check(input string req, input int addr, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = ADDR_W'(addr);
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic wait_tick(input int n);
    while (tick_num < n) @(negedge clk);
  endtask

  // Watchdog on the bench itself
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int s;
    int r;
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    cpu_halt  = 1'b0;
    cpu_sleep = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1", {31'b0, irq}, 32'h0);
    check("R1", {31'b0, sys_reset}, 32'h0);
    rd_check("R1", 1, 32'h0);
    rd_check("R1", 2, 32'h0);
    rd_check("R1", 3, 32'h0);
    rd_check("R1", 4, 32'h0);

    // R2: without start nothing counts and keys do nothing
    wr(1, 32'h0);
    wr(2, 32'd3);
    wr(3, 32'h1);
    wr(8, KEY);
    wait_tick(tick_num + 20);
    rd_check("R2", 4, 32'h0000_0001);
    rd_check("R2", 5, 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4 R10 R6: no interrupt, halt ignored because run_halt is set
    cpu_halt = 1'b1;
    wr(1, 32'h1);
    wr(2, 32'd4);
    wr(3, 32'h3);
    wr(0, 32'h1);
    s = tick_num;
    expect_evt(K_RISE, s + 4);
    expect_evt(K_FALL, s + 5);
    wr(2, 32'd9);
    wr(1, 32'h4);
    rd_check("R10", 2, 32'd4);
    rd_check("R10", 1, 32'h1);
    rd_check("R8", 4, 32'h8000_0003);
    wait_tick(s + 6);
    cpu_halt = 1'b0;
    rd_check("R6", 1, 32'h0);
    rd_check("R6", 2, 32'h0);
    rd_check("R6", 4, 32'h0);
    check("R4", {31'b0, irq}, 32'h0);

    // R7 R8 R5 R11: reload needs all enabled channels, then interrupt path
    wr(1, 32'h4);
    wr(2, 32'd6);
    wr(3, 32'h5);
    wr(0, 32'h1);
    s = tick_num;
    wait_tick(s + 2);
    wr(8, KEY);
    rd_check("R8", 4, 32'h8000_0004);
    wr(10, 32'h1234_5678);
    rd_check("R7", 4, 32'h8000_0004);
    wr(9, KEY);
    rd_check("R7", 4, 32'h8000_0004);
    wr(10, KEY);
    r = tick_num;
    rd_check("R7", 4, 32'h8000_0005);
    rd_check("R7", 5, 32'd6);
    expect_evt(K_IRQ,  r + 6);
    expect_evt(K_RISE, r + 8);
    expect_evt(K_FALL, r + 9);
    wait_tick(r + 6);
    check("R5", {31'b0, irq}, 32'h1);
    wr(8, KEY);
    wr(10, KEY);
    wr(0, 32'h1);
    wait_tick(r + 10);
    check("R11", {31'b0, irq}, 32'h0);
    rd_check("R6", 4, 32'h0);

    // R9: halt pauses counting when run_halt is clear; sleep runs
    cpu_sleep = 1'b1;
    wr(1, 32'h2);
    wr(2, 32'd5);
    wr(3, 32'h1);
    wr(0, 32'h1);
    s = tick_num;
    cpu_halt = 1'b1;
    wait_tick(s + 10);
    rd_check("R9", 5, 32'd5);
    cpu_halt = 1'b0;
    expect_evt(K_RISE, s + 15);
    expect_evt(K_FALL, s + 16);
    wait_tick(s + 17);
    cpu_sleep = 1'b0;

    // All expected edges seen
    check("R3", exp_kind.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule